// File: doc/BRIEF.md
# Third-Order Noise-Shaped Fractional Divide-Ratio Generator

This block drives the feedback divider of a fractional-N synthesizer. It holds an 8-bit integer word and a 14-bit fractional word. On every feedback-cycle strobe it produces the integer modulus for the next count of a pulse-swallow divider. That modulus is the integer word plus a small signed offset. The offset comes from three cascaded 14-bit accumulators, whose overflow bits are combined through first and second differences. The long-run average of the modulus is therefore integer + fraction/16384, and the quantisation error is pushed to high frequencies, where the loop filter removes it.

New words take effect through a single-cycle load strobe. The load also clears every accumulator and delay stage, so modulation always restarts from a known state. The divider cannot count below 31, so a flag reports when the held integer word is under that limit. The analog loop, the prescaler and the counters themselves are outside this block.

Top module: `sdm_divider_ctrl`

## Requirements
- R1: After reset, `modulus` is 0, `offset` is 0 and `int_invalid` is 1 (the held integer word is 0).
- R2: In the clock cycle after `load` is high, `modulus` equals the `int_in` value sampled with it and `offset` is 0. `load` takes priority over `step`.
- R3: While the held fraction is 0, every step yields offset 0, so the modulus stays equal to the held integer word.
- R4: `offset` is a 4-bit two's-complement value that always lies between -3 and +4 inclusive.
- R5: Whenever `int_invalid` is 0, `modulus` equals the held integer word plus the signed `offset`.
- R6: `modulus` and `offset` change only in the cycle after a `step` or `load`. They hold their value while both strobes are low.
- R7: For an even held fraction F, the offsets of the first 16384 steps after a load sum to exactly F.
- R8: For any held fraction F, the offsets of the first 65536 steps after a load sum to exactly 4*F.
- R9: After a load, `int_invalid` is 1 when the loaded integer word is below 31 and 0 otherwise (30 is flagged, 31 is not).
- R10: A load clears all accumulators and delay stages. Reloading the same words repeats the same offset sequence from its start.
- R11: `int_in` and `frac_in` have no effect unless `load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Captures `int_in`/`frac_in` and restarts modulation |
| step | input | 1 | One pulse per feedback divider cycle |
| int_in | input | 8 | Integer part of the divide ratio |
| frac_in | input | 14 | Fractional part, in units of 1/16384 |
| modulus | output | 9 | Integer modulus for the current divider cycle |
| offset | output | 4 | Signed offset added to the integer word |
| int_invalid | output | 1 | Held integer word is below the divider minimum |

## Verification
The hardest property to reach from the ports is the exact long-term average. The boundary carry terms of the differentiating stages cancel only when all three accumulators return to zero together. That happens after 16384 steps for even fractions and after 65536 steps for odd ones. The stimulus loads a word and keeps the step strobe high for exactly that many cycles, totalling the offset output on each cycle. An even and an odd fraction are both run this way. A reload with identical words shows that the load clears the hidden accumulator state, because the opening offsets repeat.

// File: rtl/sdm_divider_ctrl.sv
module sdm_divider_ctrl #(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 14,
  parameter int MIN_INT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [INT_W:0]    modulus,
  output logic signed [3:0] offset,
  output logic              int_invalid
);

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q, acc1, acc2, acc3;
  logic              c2_d, c3_d, c3_dd;
  logic [FRAC_W:0]   s1, s2, s3;
  int                off_sum, mod_sum;

  assign s1 = {1'b0, acc1} + {1'b0, frac_q};
  assign s2 = {1'b0, acc2} + {1'b0, s1[FRAC_W-1:0]};
  assign s3 = {1'b0, acc3} + {1'b0, s2[FRAC_W-1:0]};

  always_comb begin
    off_sum = int'(s1[FRAC_W]) + int'(s2[FRAC_W]) - int'(c2_d)
            + int'(s3[FRAC_W]) - 2 * int'(c3_d) + int'(c3_dd);
    mod_sum = int'(int_q) + off_sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q       <= '0;
      frac_q      <= '0;
      acc1        <= '0;
      acc2        <= '0;
      acc3        <= '0;
      c2_d        <= 1'b0;
      c3_d        <= 1'b0;
      c3_dd       <= 1'b0;
      modulus     <= '0;
      offset      <= '0;
      int_invalid <= 1'b1;
    end else if (load) begin
      int_q       <= int_in;
      frac_q      <= frac_in;
      acc1        <= '0;
      acc2        <= '0;
      acc3        <= '0;
      c2_d        <= 1'b0;
      c3_d        <= 1'b0;
      c3_dd       <= 1'b0;
      modulus     <= {1'b0, int_in};
      offset      <= '0;
      int_invalid <= int'(int_in) < MIN_INT;
    end else if (step) begin
      acc1    <= s1[FRAC_W-1:0];
      acc2    <= s2[FRAC_W-1:0];
      acc3    <= s3[FRAC_W-1:0];
      c2_d    <= s2[FRAC_W];
      c3_d    <= s3[FRAC_W];
      c3_dd   <= c3_d;
      offset  <= 4'(off_sum);
      modulus <= (INT_W+1)'(mod_sum);
    end
  end

endmodule

// File: rtl/sdm_divider_ctrl_chk.sv
module sdm_divider_ctrl_chk #(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 14,
  parameter int MIN_INT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              step,
  input logic [INT_W-1:0]  int_in,
  input logic [INT_W-1:0]  int_q,
  input logic [FRAC_W-1:0] frac_q,
  input logic [INT_W:0]    modulus,
  input logic signed [3:0] offset,
  input logic              int_invalid
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (offset == 4'sd0) && (int'(modulus) == int'($past(int_in))));

  p_zero_frac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q == '0) |-> (offset == 4'sd0));

  p_offset_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offset) >= -3) && (int'(offset) <= 4));

  p_mod_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !int_invalid |-> (int'(modulus) == int'(int_q) + int'(offset)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(modulus) && $stable(offset)));

  p_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (int_invalid == (int'($past(int_in)) < MIN_INT)));

endmodule

bind sdm_divider_ctrl sdm_divider_ctrl_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_INT(MIN_INT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .step(step), .int_in(int_in),
  .int_q(int_q), .frac_q(frac_q), .modulus(modulus), .offset(offset),
  .int_invalid(int_invalid)
);

// File: tb/sdm_divider_ctrl_tb.sv
module sdm_divider_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, step = 1'b0;
  logic [7:0]  int_in = '0;
  logic [13:0] frac_in = '0;
  logic [8:0]  modulus;
  logic signed [3:0] offset;
  logic int_invalid;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sdm_divider_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .int_in(int_in),
    .frac_in(frac_in), .modulus(modulus), .offset(offset), .int_invalid(int_invalid)
  );

  localparam int NV = 6;
  localparam int TV_INT [NV] = '{31, 100, 255, 30, 64, 200};
  localparam int TV_FRAC[NV] = '{1, 8192, 16383, 0, 777, 12345};
  localparam int TV_INV [NV] = '{0, 0, 0, 1, 0, 0};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_load(input int iv, input int fv);
    @(negedge clk);
    int_in = 8'(iv); frac_in = 14'(fv); load = 1'b1; step = 1'b0;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_steps(input int n, input int iv, input bit chk_each, output int sum);
    int bad_rng = 0, bad_mod = 0;
    sum = 0;
    step = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sum += int'(offset);
      if (chk_each) begin
        if (int'(offset) < -3 || int'(offset) > 4) bad_rng++;
        if (int'(modulus) != iv + int'(offset)) bad_mod++;
      end
    end
    step = 1'b0;
    if (chk_each) begin
      check(bad_rng == 0, "R4 offset range", bad_rng, 0);
      check(bad_mod == 0, "R5 modulus=int+offset", bad_mod, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s;
    int seq_a[16];
    repeat (3) @(negedge clk);
    check(modulus == 9'd0, "R1 reset modulus", int'(modulus), 0);
    check(offset == 4'sd0, "R1 reset offset", int'(offset), 0);
    check(int_invalid == 1'b1, "R1 reset invalid", int'(int_invalid), 1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      do_load(TV_INT[v], TV_FRAC[v]);
      check(int'(modulus) == TV_INT[v], "R2 load modulus", int'(modulus), TV_INT[v]);
      check(int'(int_invalid) == TV_INV[v], "R9 invalid flag", int'(int_invalid), TV_INV[v]);
      run_steps(64, TV_INT[v], TV_INV[v] == 0, s);
      if (TV_FRAC[v] == 0)
        check(int'(modulus) == TV_INT[v], "R3 zero fraction modulus", int'(modulus), TV_INT[v]);
    end

    // R2: load wins over step
    @(negedge clk);
    int_in = 8'd77; frac_in = 14'd16383; load = 1'b1; step = 1'b1;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    check(int'(modulus) == 77 && offset == 4'sd0, "R2 load priority", int'(modulus), 77);

    // R6: hold without strobes
    run_steps(5, 77, 1'b0, s);
    s = int'(modulus);
    repeat (4) @(negedge clk);
    check(int'(modulus) == s, "R6 hold modulus", int'(modulus), s);

    // R3 + R11
    do_load(50, 0);
    int_in = 8'd200; frac_in = 14'd5000;
    run_steps(20, 50, 1'b1, s);
    check(s == 0, "R3 zero fraction sum", s, 0);
    check(int'(modulus) == 50, "R11 inputs ignored", int'(modulus), 50);

    // R10: reload repeats sequence
    do_load(100, 12345);
    step = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); seq_a[k] = int'(offset);
    end
    step = 1'b0;
    run_steps(50, 100, 1'b0, s);
    do_load(100, 12345);
    step = 1'b1;
    begin
      int mism = 0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (int'(offset) != seq_a[k]) mism++;
      end
      step = 1'b0;
      check(mism == 0, "R10 restart sequence", mism, 0);
    end

    // R7: even fraction over 16384 steps
    do_load(60, 10000);
    run_steps(16384, 60, 1'b1, s);
    check(s == 10000, "R7 sum over 2^14", s, 10000);

    // R8: odd fraction over 65536 steps
    do_load(200, 12345);
    run_steps(65536, 200, 1'b1, s);
    check(s == 4 * 12345, "R8 sum over 2^16", s, 4 * 12345);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule